// File: doc/BRIEF.md
# Pin-Level I/O Test Controller

This block runs the board-test features of a line transceiver's digital pin ring. A test output always reports the parity of the monitored digital inputs. A board tester can therefore toggle any single input pin and see a change on one output pin. A test-enable pin and a three-bit mode-select code choose among three output behaviours:
- normal operation, where each output carries its functional source;
- a forced mode, where every digital output copies one dedicated test input pin;
- a floating mode, where every output enable is dropped so that in-circuit test equipment can drive the nets.

Neither test mode takes effect until an unlock pattern has been applied. The pattern is four mode codes in order, each captured on a rising edge of test-enable. The block owns no pads. It drives one output level and one active-high output enable per pin, and a top level builds the tri-state pads from them. All asynchronous pin inputs (monitored inputs, test-enable, mode code, test input) pass through a synchronizer of `SYNC_STAGES` flops. The output register then adds one more cycle. At any sensible clock this settles well inside a sub-microsecond budget.

Top module: `pit_ctrl`

## Requirements
- R1: In normal behaviour, output bit `N_FUNC` (the parity test output) equals the XOR of all `in_pins` bits XOR 1. The 1 accounts for the master reset pin, which is high whenever the block runs. So an even count of ones in `in_pins` gives 1 and an odd count gives 0.
- R2: In normal behaviour, `pin_out[N_FUNC-1:0]` follows `func_src` with one register of delay, and every `pin_oe` bit is 1.
- R3: When armed, with test-enable high and mode code 3'b110 (bit 2 is the first select pin, bit 0 the last), every `pin_out` bit, the parity output included, equals `test_in`, and every `pin_oe` bit is 1.
- R4: When armed, with test-enable high and mode code 3'b100, every `pin_oe` bit is 0 and `pin_out` is 0.
- R5: Until the unlock pattern has completed, codes 3'b110 and 3'b100 with test-enable high leave the outputs in normal behaviour.
- R6: The unlock pattern is the four codes in `UNLOCK_SEQ`, with step i in bits [3i+2:3i]. The default is 3'b011, 3'b101, 3'b010, 3'b111 in that order. Each code is sampled on a rising edge of test-enable, and the block arms only when all four match in order.
- R7: A rising edge of test-enable whose code does not match the expected step sends the detector back to step 0, and that sample is discarded. A pattern broken partway therefore has to be restarted from its first code.
- R8: Asserting `rst_n` low disarms the block, and it stays disarmed until the full pattern is applied again.
- R9: When armed, any other code with test-enable high, or any code with test-enable low, gives normal behaviour.
- R10: A change on `test_in` or `in_pins` reaches `pin_out` exactly `SYNC_STAGES`+1 rising clock edges later.
- R11: During and right after reset, every `pin_oe` bit is 1 and the block is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Master reset, active low, asynchronous |
| in_pins | input | N_IN | Monitored digital inputs covered by the parity output |
| test_en | input | 1 | Test-enable pin |
| mode_pins | input | 3 | Mode-select code, bit 2 = first select pin |
| test_in | input | 1 | Level copied to all outputs in forced mode |
| func_src | input | N_FUNC | Normal functional sources for the data outputs |
| pin_out | output | N_FUNC+1 | Output levels; bit N_FUNC is the parity test output |
| pin_oe | output | N_FUNC+1 | Active-high output enables, one per output |

## Verification
The bench builds the block with `SYNC_STAGES` = 3, `N_IN` = 5 and `N_FUNC` = 3, and keeps the default unlock pattern. The deeper synchronizer makes the exact latency check of R10 distinguish the chain length from an off-by-one. Five monitored inputs let both parities be produced with several distinct bit patterns. Three functional outputs plus the parity output show that forced and floating behaviour cover the whole pin set, including the parity pin itself.

// File: rtl/pit_pkg.sv
package pit_pkg;

    localparam int MODE_W = 3;

    localparam logic [MODE_W-1:0] CODE_FORCE = 3'b110;
    localparam logic [MODE_W-1:0] CODE_FLOAT = 3'b100;

    typedef enum logic [1:0] {
        PM_NORMAL = 2'd0,
        PM_FORCE  = 2'd1,
        PM_FLOAT  = 2'd2
    } pin_mode_e;

    // Output behaviour chosen from the arm flag and the synchronized pins.
    function automatic pin_mode_e pick_mode(
        input logic              armed,
        input logic              en,
        input logic [MODE_W-1:0] code
    );
        pin_mode_e m;
        m = PM_NORMAL;
        if (armed && en) begin
            if (code == CODE_FORCE) begin
                m = PM_FORCE;
            end else if (code == CODE_FLOAT) begin
                m = PM_FLOAT;
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/pit_sync.sv
module pit_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [STAGES-1:0][W-1:0] chain_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            logic [W-1:0] stage_d;
            if (g == 0) begin : g_first
                assign stage_d = async_i;
            end else begin : g_next
                assign stage_d = chain_q[g-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[g] <= '0;
                end else begin
                    chain_q[g] <= stage_d;
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/pit_unlock.sv
module pit_unlock #(
    parameter int                          SEQ_LEN    = 4,
    parameter logic [SEQ_LEN*pit_pkg::MODE_W-1:0] UNLOCK_SEQ = 12'b111_010_101_011
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en_s,
    input  logic [pit_pkg::MODE_W-1:0] code_s,
    output logic                       armed,
    output logic                       en_rise
);
    import pit_pkg::*;

    localparam int STEP_W = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1;
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(SEQ_LEN - 1);

    typedef struct packed {
        logic [STEP_W-1:0] step;
        logic              armed;
        logic              en_prev;
    } ulk_t;

    ulk_t st_d, st_q;
    logic [MODE_W-1:0] want;

    always_comb begin
        want     = UNLOCK_SEQ[st_q.step*MODE_W +: MODE_W];
        en_rise  = en_s && !st_q.en_prev;
        st_d     = st_q;
        st_d.en_prev = en_s;
        if (en_rise && !st_q.armed) begin
            if (code_s == want) begin
                if (st_q.step == LAST_STEP) begin
                    st_d.armed = 1'b1;
                    st_d.step  = '0;
                end else begin
                    st_d.step = st_q.step + 1'b1;
                end
            end else begin
                st_d.step = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign armed = st_q.armed;

endmodule

// File: rtl/pit_outmux.sv
module pit_outmux #(
    parameter int N_IN   = 6,
    parameter int N_FUNC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pit_pkg::pin_mode_e sel,
    input  logic [N_IN-1:0]   in_s,
    input  logic              tin_s,
    input  logic [N_FUNC-1:0] func_src,
    output logic [N_FUNC:0]   out_q,
    output logic [N_FUNC:0]   oe_q
);
    import pit_pkg::*;

    localparam int N_OUT = N_FUNC + 1;

    logic [N_OUT-1:0] out_d, oe_d;
    logic             par;

    always_comb begin
        // master reset pin is high whenever this logic runs
        par   = (^in_s) ^ 1'b1;
        out_d = {par, func_src};
        oe_d  = '1;
        case (sel)
            PM_FORCE: begin
                out_d = {N_OUT{tin_s}};
            end
            PM_FLOAT: begin
                out_d = '0;
                oe_d  = '0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
            oe_q  <= '1;
        end else begin
            out_q <= out_d;
            oe_q  <= oe_d;
        end
    end

endmodule

// File: rtl/pit_ctrl.sv
module pit_ctrl #(
    parameter int   N_IN        = 6,
    parameter int   N_FUNC      = 3,
    parameter int   SYNC_STAGES = 2,
    parameter int   SEQ_LEN     = 4,
    parameter logic [SEQ_LEN*3-1:0] UNLOCK_SEQ = 12'b111_010_101_011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IN-1:0]   in_pins,
    input  logic              test_en,
    input  logic [2:0]        mode_pins,
    input  logic              test_in,
    input  logic [N_FUNC-1:0] func_src,
    output logic [N_FUNC:0]   pin_out,
    output logic [N_FUNC:0]   pin_oe
);
    import pit_pkg::*;

    localparam int SYNC_W = N_IN + 1 + MODE_W + 1;

    logic [SYNC_W-1:0] raw, synced;
    logic [N_IN-1:0]   in_s;
    logic              en_s;
    logic [MODE_W-1:0] code_s;
    logic              tin_s;
    logic              armed;
    logic              en_rise;
    pin_mode_e         sel;

    assign raw = {in_pins, test_en, mode_pins, test_in};

    pit_sync #(
        .W      (SYNC_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw),
        .sync_o  (synced)
    );

    assign {in_s, en_s, code_s, tin_s} = synced;

    pit_unlock #(
        .SEQ_LEN    (SEQ_LEN),
        .UNLOCK_SEQ (UNLOCK_SEQ)
    ) u_unlock (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_s    (en_s),
        .code_s  (code_s),
        .armed   (armed),
        .en_rise (en_rise)
    );

    assign sel = pick_mode(armed, en_s, code_s);

    pit_outmux #(
        .N_IN   (N_IN),
        .N_FUNC (N_FUNC)
    ) u_outmux (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel),
        .in_s     (in_s),
        .tin_s    (tin_s),
        .func_src (func_src),
        .out_q    (pin_out),
        .oe_q     (pin_oe)
    );

endmodule

// File: rtl/pit_ctrl_chk.sv
module pit_ctrl_chk #(
    parameter int N_IN   = 6,
    parameter int N_FUNC = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_FUNC:0]   pin_out,
    input logic [N_FUNC:0]   pin_oe,
    input logic [N_IN-1:0]   in_s,
    input logic              tin_s,
    input logic [1:0]        sel,
    input logic              armed,
    input logic              en_rise
);

    localparam int N_OUT = N_FUNC + 1;

    assert_parity_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'd0) |=> (pin_out[N_FUNC] == ((^$past(in_s)) ^ 1'b1)));

    assert_normal_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'd0) |=> (pin_oe == {N_OUT{1'b1}}));

    assert_force_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'd1) |=> (pin_out == {N_OUT{$past(tin_s)}} && pin_oe == {N_OUT{1'b1}}));

    assert_float_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'd2) |=> (pin_oe == '0));

    assert_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> (pin_oe == {N_OUT{1'b1}}));

    assert_arm_on_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(en_rise));

    assert_arm_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> armed);

endmodule

bind pit_ctrl pit_ctrl_chk #(
    .N_IN   (N_IN),
    .N_FUNC (N_FUNC)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .in_s    (in_s),
    .tin_s   (tin_s),
    .sel     (sel),
    .armed   (armed),
    .en_rise (en_rise)
);

// File: tb/pit_ctrl_tb.sv
module pit_ctrl_tb;

    localparam int SS = 3;
    localparam int NI = 5;
    localparam int NF = 3;
    localparam int NO = NF + 1;
    localparam int SETTLE = SS + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NI-1:0] in_pins = '0;
    logic          test_en = 1'b0;
    logic [2:0]    mode_pins = 3'b000;
    logic          test_in = 1'b0;
    logic [NF-1:0] func_src = '0;
    logic [NF:0]   pin_out;
    logic [NF:0]   pin_oe;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    pit_ctrl #(
        .N_IN        (NI),
        .N_FUNC      (NF),
        .SYNC_STAGES (SS)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_pins   (in_pins),
        .test_en   (test_en),
        .mode_pins (mode_pins),
        .test_in   (test_in),
        .func_src  (func_src),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        test_en = 1'b0;
        edges(2);
        rst_n = 1'b1;
        edges(SETTLE);
    endtask

    task automatic pulse_code(input logic [2:0] c);
        mode_pins = c;
        edges(SETTLE);
        test_en = 1'b1;
        edges(SETTLE);
        test_en = 1'b0;
        edges(SETTLE);
    endtask

    task automatic unlock();
        pulse_code(3'b011);
        pulse_code(3'b101);
        pulse_code(3'b010);
        pulse_code(3'b111);
    endtask

    // Applies the forced-mode code; reports whether outputs follow test_in.
    task automatic probe_force(output logic forced);
        logic a, b;
        mode_pins = 3'b110;
        test_in = 1'b1;
        edges(SETTLE);
        test_en = 1'b1;
        edges(SETTLE);
        a = (pin_out == {NO{1'b1}});
        test_in = 1'b0;
        func_src = '1;
        edges(SETTLE);
        b = (pin_out == {NO{1'b0}});
        forced = a && b;
        test_en = 1'b0;
        func_src = '0;
        edges(SETTLE);
    endtask

    task automatic t_reset();
        logic forced;
        @(negedge clk);
        chk(pin_oe == '1, "R11 oe during reset", pin_oe, 4'hf);
        rst_n = 1'b1;
        edges(1);
        chk(pin_oe == '1, "R11 oe after reset", pin_oe, 4'hf);
        edges(SETTLE);
        probe_force(forced);
        chk(!forced, "R11 disarmed after reset", forced, 0);
    endtask

    task automatic t_parity();
        logic [NI-1:0] pats [5] = '{5'b00000, 5'b00001, 5'b10110, 5'b11111, 5'b01100};
        foreach (pats[i]) begin
            in_pins = pats[i];
            edges(SETTLE);
            chk(pin_out[NF] == ((^pats[i]) ^ 1'b1), "R1 parity", pin_out[NF], (^pats[i]) ^ 1'b1);
        end
        in_pins = '0;
    endtask

    task automatic t_normal();
        logic [NF-1:0] fv [3] = '{3'b101, 3'b010, 3'b111};
        foreach (fv[i]) begin
            func_src = fv[i];
            edges(1);
            chk(pin_out[NF-1:0] == fv[i], "R2 func follow", pin_out[NF-1:0], fv[i]);
            chk(pin_oe == '1, "R2 oe high", pin_oe, 4'hf);
        end
        func_src = '0;
        edges(1);
    endtask

    task automatic t_locked();
        logic forced;
        probe_force(forced);
        chk(!forced, "R5 force ignored when locked", forced, 0);
        mode_pins = 3'b100;
        edges(SETTLE);
        test_en = 1'b1;
        edges(SETTLE);
        chk(pin_oe == '1, "R5 float ignored when locked", pin_oe, 4'hf);
        test_en = 1'b0;
        edges(SETTLE);
    endtask

    task automatic t_broken_seq();
        logic forced;
        pulse_code(3'b011);
        pulse_code(3'b101);
        pulse_code(3'b000);
        pulse_code(3'b010);
        pulse_code(3'b111);
        probe_force(forced);
        chk(!forced, "R7 broken pattern does not arm", forced, 0);
        pulse_code(3'b011);
        pulse_code(3'b101);
        pulse_code(3'b010);
        probe_force(forced);
        chk(!forced, "R6 three steps do not arm", forced, 0);
        do_reset();
        unlock();
        probe_force(forced);
        chk(forced, "R6 full pattern arms", forced, 1);
    endtask

    task automatic t_force_latency();
        mode_pins = 3'b110;
        test_in = 1'b0;
        edges(SETTLE);
        test_en = 1'b1;
        edges(SETTLE);
        chk(pin_out == '0 && pin_oe == '1, "R3 force low", pin_out, 0);
        test_in = 1'b1;
        edges(SS);
        chk(pin_out == '0, "R10 not before latency", pin_out, 0);
        edges(1);
        chk(pin_out == '1, "R10 arrives at latency", pin_out, 4'hf);
        chk(pin_oe == '1, "R3 force oe", pin_oe, 4'hf);
        test_en = 1'b0;
        test_in = 1'b0;
        edges(SETTLE);
    endtask

    task automatic t_float();
        mode_pins = 3'b100;
        edges(SETTLE);
        test_en = 1'b1;
        edges(SETTLE);
        chk(pin_oe == '0, "R4 float oe", pin_oe, 0);
        chk(pin_out == '0, "R4 float level", pin_out, 0);
        test_en = 1'b0;
        edges(SETTLE);
        chk(pin_oe == '1, "R9 test_en low normal", pin_oe, 4'hf);
    endtask

    task automatic t_other_code();
        mode_pins = 3'b010;
        func_src = 3'b110;
        in_pins = 5'b00111;
        test_in = 1'b1;
        edges(SETTLE);
        test_en = 1'b1;
        edges(SETTLE);
        chk(pin_oe == '1, "R9 other code oe", pin_oe, 4'hf);
        chk(pin_out == {1'b0, 3'b110}, "R9 other code normal", pin_out, 4'h6);
        mode_pins = 3'b110;
        test_en = 1'b0;
        test_in = 1'b0;
        edges(SETTLE);
        chk(pin_out == {1'b0, 3'b110}, "R9 force code with test_en low", pin_out, 4'h6);
        in_pins = 5'b00110;
        edges(SS + 1);
        chk(pin_out[NF] == 1'b1, "R10 input to parity latency", pin_out[NF], 1);
        func_src = '0;
        in_pins = '0;
        edges(SETTLE);
    endtask

    task automatic t_reset_disarms();
        logic forced;
        do_reset();
        probe_force(forced);
        chk(!forced, "R8 reset disarms", forced, 0);
    endtask

    initial begin
        fork
            begin
                edges(3);
                t_reset();
                t_parity();
                t_normal();
                t_locked();
                t_broken_seq();
                t_force_latency();
                t_float();
                t_other_code();
                t_reset_disarms();
            end
            begin
                repeat (100000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule